// File: doc/BRIEF.md
# Interrupt Line Slot Allocator

This block keeps the mapping table behind an interrupt crossbar. The crossbar has a fixed set of output interrupt lines, and each line has a selector register that picks which input source drives it. The allocator tracks every line as free, reserved, bypassed, or allocated and holding a source number. On each change it issues one selector write toward the crossbar, so the crossbar registers always follow the table.

The reserved and bypassed line masks are sampled while reset is held. When reset is released, the block walks every free line in ascending order and writes the safe source to each. After that it accepts one request at a time over a valid/ready handshake. An allocate request names a first source and a count. The block gives each source, in turn, the highest-numbered line still free. A free request names a line and detaches it, pushing the safe source back onto that line's selector. Every request ends with a one-cycle done pulse that carries an error flag, a line index, a source number and a grant count.

Top module: `irq_slot_alloc`

## Requirements
- R1: While reset is low, lines whose bit is set in `cfg_byp_mask` become bypassed. Lines set only in `cfg_rsv_mask` become reserved. All other lines become free. `cfg_err` goes high after reset exactly when either mask has a bit set at an index of `NUM_LINES` or above (bits 12 to 15 at default), and it holds that value until the next reset.
- R2: After reset is released, `req_ready` stays low during a sweep. The sweep issues one selector write per cycle, carrying `SAFE_SRC`, to each free line in ascending line order. No other line is written.
- R3: An allocation gives each source the highest-indexed line that is free at that moment.
- R4: An allocate request with first source S and count N gives sources S, S+1, ..., S+N-1 lines in that order. Each grant issues exactly one selector write of (line, source) and marks the line allocated. On success, `rsp_err`=0, `rsp_count`=N, and `rsp_line` and `rsp_src` give the last grant.
- R5: When N is 0, or S+N is greater than `NUM_SRCS`, the request completes with `rsp_err`=1 and `rsp_count`=0. It issues no write and changes no line.
- R6: When the free lines run out partway through a request, the request completes with `rsp_err`=1. Grants already made stay in place, and `rsp_count` gives their number. `rsp_line` is the last line granted, or 0 if none was granted.
- R7: A free request (`req_op`=1) on a free or allocated line marks that line free. It issues one selector write of `SAFE_SRC` to that line and completes with `rsp_err`=0. `rsp_src` returns the source the line held, or `SAFE_SRC` if the line was already free. There is no use count: a single free always releases the line.
- R8: A free request on a reserved or bypassed line, or on an index of `NUM_LINES` or above, completes with `rsp_err`=1. It issues no write and changes no line.
- R9: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the acceptance of a valid allocation until its completion. `rsp_done` is high for a single cycle per request.
- R10: Reserved and bypassed lines are never granted and never change state until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; masks are loaded while low |
| cfg_rsv_mask | input | 16 | Lines to mark reserved |
| cfg_byp_mask | input | 16 | Lines to mark bypassed (wins over reserved) |
| cfg_err | output | 1 | A mask marks a line index that does not exist |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_src | input | 6 | First source number (allocate) |
| req_cnt | input | 3 | Number of sources (allocate) |
| req_line | input | 4 | Line index (free) |
| wr_valid | output | 1 | Selector write strobe toward the crossbar |
| wr_line | output | 4 | Line whose selector is written |
| wr_src | output | 6 | Source value written |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request failed in whole or in part |
| rsp_line | output | 4 | Last line granted, or line freed |
| rsp_src | output | 6 | Last source granted, or source detached |
| rsp_count | output | 3 | Number of grants made |

## Verification
The bench tests the search order in three ways. It skips over a bypassed line inside a block request, checks that a freed line is taken again ahead of lower free lines, and runs out of lines partway through a block. A design that searched upward, or did not skip the bypassed line, would issue writes to the wrong lines. It also runs the source-range boundary, where S+N equals `NUM_SRCS` and where it exceeds it by one. An off-by-one comparator would reject the first case or accept the second and corrupt the table. Free requests go to a reserved line, a line marked in both masks, an index that does not exist, and a line freed twice. These cases catch a design that writes through protected entries or that keeps a use count.

// File: rtl/irq_slot_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the interrupt line slot allocator.
// Assumes: a 2-bit entry state is enough; controller states are one-hot-free binary.
package irq_slot_pkg;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_RSV   = 2'd1,
        ENT_BYP   = 2'd2,
        ENT_ALLOC = 2'd3
    } ent_state_t;

    typedef enum logic [1:0] {
        C_INIT  = 2'd0,
        C_IDLE  = 2'd1,
        C_ALLOC = 2'd2
    } ctl_state_t;

    localparam logic OP_ALLOC = 1'b0;
    localparam logic OP_FREE  = 1'b1;

endpackage

// File: rtl/slot_table.sv
`timescale 1ns/1ps
// Line table: one state field and one source field per output line.
// Loads the reserved/bypassed masks during reset and flags mask bits that
// name nonexistent lines. Assumes set and clear never target the same line
// in one cycle (the controller never issues both together).
module slot_table
    import irq_slot_pkg::*;
#(
    parameter int NUM_LINES = 12,
    parameter int LINE_W    = 4,
    parameter int MASK_W    = 16,
    parameter int SRC_W     = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [MASK_W-1:0]                rsv_mask,
    input  logic [MASK_W-1:0]                byp_mask,
    input  logic                             set_en,
    input  logic [LINE_W-1:0]                set_idx,
    input  logic [SRC_W-1:0]                 set_src,
    input  logic                             clr_en,
    input  logic [LINE_W-1:0]                clr_idx,
    output ent_state_t [NUM_LINES-1:0]       st,
    output logic [NUM_LINES-1:0][SRC_W-1:0]  src,
    output logic [NUM_LINES-1:0]             free_vec,
    output logic                             cfg_err
);

    localparam logic [MASK_W-1:0] ONES    = '1;
    localparam logic [MASK_W-1:0] HI_MASK = ONES << NUM_LINES;

    // Capture whether any mask names a line beyond the table.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= |((rsv_mask | byp_mask) & HI_MASK);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
        ent_state_t        st_q;
        logic [SRC_W-1:0]  src_q;

        // Per-line state: reset from masks, then grant or release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= byp_mask[i] ? ENT_BYP : (rsv_mask[i] ? ENT_RSV : ENT_FREE);
                src_q <= '0;
            end else if (set_en && set_idx == LINE_W'(i)) begin
                st_q  <= ENT_ALLOC;
                src_q <= set_src;
            end else if (clr_en && clr_idx == LINE_W'(i)) begin
                st_q  <= ENT_FREE;
            end
        end

        assign st[i]       = st_q;
        assign src[i]      = src_q;
        assign free_vec[i] = (st_q == ENT_FREE);

        assert_rsv_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            st_q == ENT_RSV |=> st_q == ENT_RSV)
            else $error("reserved line %0d changed state", i);

        assert_byp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            st_q == ENT_BYP |=> st_q == ENT_BYP)
            else $error("bypassed line %0d changed state", i);

        assert_grant_records_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_en && set_idx == LINE_W'(i)) |=> (st_q == ENT_ALLOC && src_q == $past(set_src)))
            else $error("grant to line %0d not recorded", i);
    end

endmodule

// File: rtl/slot_finder.sv
`timescale 1ns/1ps
// Free-line search: reports the highest-indexed free line.
// Purely combinational; assumes free_vec is valid whenever it is read.
module slot_finder #(
    parameter int NUM_LINES = 12,
    parameter int LINE_W    = 4
) (
    input  logic [NUM_LINES-1:0] free_vec,
    output logic                 found,
    output logic [LINE_W-1:0]    hit
);

    // Scan upward so the last free line seen, the highest, wins.
    always_comb begin
        found = 1'b0;
        hit   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (free_vec[i]) begin
                found = 1'b1;
                hit   = LINE_W'(i);
            end
        end
    end

endmodule

// File: rtl/slot_ctrl.sv
`timescale 1ns/1ps
// Request controller: post-reset safe sweep, request handshake, block
// allocation one source per cycle, release, and the response/write outputs.
// Assumes the table reflects last cycle's set/clear and the finder is combinational.
module slot_ctrl
    import irq_slot_pkg::*;
#(
    parameter int NUM_LINES = 12,
    parameter int NUM_SRCS  = 64,
    parameter int LINE_W    = 4,
    parameter int SRC_W     = 6,
    parameter int CNT_W     = 3,
    parameter int SAFE_SRC  = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic                             req_op,
    input  logic [SRC_W-1:0]                 req_src,
    input  logic [CNT_W-1:0]                 req_cnt,
    input  logic [LINE_W-1:0]                req_line,
    input  ent_state_t [NUM_LINES-1:0]       st,
    input  logic [NUM_LINES-1:0][SRC_W-1:0]  src,
    input  logic [NUM_LINES-1:0]             free_vec,
    input  logic                             found,
    input  logic [LINE_W-1:0]                hit,
    output logic                             set_en,
    output logic [LINE_W-1:0]                set_idx,
    output logic [SRC_W-1:0]                 set_src,
    output logic                             clr_en,
    output logic [LINE_W-1:0]                clr_idx,
    output logic                             wr_valid,
    output logic [LINE_W-1:0]                wr_line,
    output logic [SRC_W-1:0]                 wr_src,
    output logic                             rsp_done,
    output logic                             rsp_err,
    output logic [LINE_W-1:0]                rsp_line,
    output logic [SRC_W-1:0]                 rsp_src,
    output logic [CNT_W-1:0]                 rsp_count
);

    localparam int               SUM_W = SRC_W + 2;
    localparam logic [SRC_W-1:0] SAFE  = SRC_W'(SAFE_SRC);

    ctl_state_t         cs;
    logic [LINE_W-1:0]  init_idx;
    logic [SRC_W-1:0]   cur_src;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   granted;
    logic               accept;
    logic               line_ok;
    logic [LINE_W-1:0]  sel;
    ent_state_t         sel_st;
    logic               free_ok;
    logic [SUM_W-1:0]   src_end;
    logic               range_bad;

    // Request decode and table update strobes.
    always_comb begin
        req_ready = (cs == C_IDLE);
        accept    = req_valid && req_ready;
        line_ok   = ({1'b0, req_line} < (LINE_W + 1)'(NUM_LINES));
        sel       = line_ok ? req_line : '0;
        sel_st    = st[sel];
        free_ok   = line_ok && (sel_st == ENT_FREE || sel_st == ENT_ALLOC);
        src_end   = SUM_W'(req_src) + SUM_W'(req_cnt);
        range_bad = (req_cnt == '0) || (src_end > SUM_W'(NUM_SRCS));
        set_en    = (cs == C_ALLOC) && found;
        set_idx   = hit;
        set_src   = cur_src;
        clr_en    = accept && (req_op == OP_FREE) && free_ok;
        clr_idx   = sel;
    end

    // Sequencer: sweep, idle/accept, and per-source grant loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs        <= C_INIT;
            init_idx  <= '0;
            cur_src   <= '0;
            left      <= '0;
            granted   <= '0;
            wr_valid  <= 1'b0;
            wr_line   <= '0;
            wr_src    <= '0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_line  <= '0;
            rsp_src   <= '0;
            rsp_count <= '0;
        end else begin
            wr_valid <= 1'b0;
            rsp_done <= 1'b0;
            case (cs)
                C_INIT: begin
                    wr_valid <= (st[init_idx] == ENT_FREE);
                    wr_line  <= init_idx;
                    wr_src   <= SAFE;
                    init_idx <= init_idx + 1'b1;
                    if (init_idx == LINE_W'(NUM_LINES - 1)) cs <= C_IDLE;
                end
                C_IDLE: begin
                    if (accept && req_op == OP_FREE) begin
                        rsp_done  <= 1'b1;
                        rsp_err   <= !free_ok;
                        rsp_line  <= req_line;
                        rsp_count <= '0;
                        rsp_src   <= (free_ok && sel_st == ENT_ALLOC) ? src[sel] : SAFE;
                        if (free_ok) begin
                            wr_valid <= 1'b1;
                            wr_line  <= sel;
                            wr_src   <= SAFE;
                        end
                    end else if (accept) begin
                        rsp_line <= '0;
                        rsp_src  <= req_src;
                        granted  <= '0;
                        if (range_bad) begin
                            rsp_done  <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_count <= '0;
                        end else begin
                            cur_src <= req_src;
                            left    <= req_cnt;
                            cs      <= C_ALLOC;
                        end
                    end
                end
                C_ALLOC: begin
                    if (found) begin
                        wr_valid <= 1'b1;
                        wr_line  <= hit;
                        wr_src   <= cur_src;
                        rsp_line <= hit;
                        rsp_src  <= cur_src;
                        granted  <= granted + 1'b1;
                        cur_src  <= cur_src + 1'b1;
                        left     <= left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            rsp_done  <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_count <= granted + 1'b1;
                            cs        <= C_IDLE;
                        end
                    end else begin
                        rsp_done  <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_count <= granted;
                        cs        <= C_IDLE;
                    end
                end
                default: cs <= C_IDLE;
            endcase
        end
    end

    assert_pick_highest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (free_vec[hit] && ((free_vec >> hit) == NUM_LINES'(1))))
        else $error("search did not return the highest free line");

    assert_bad_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_ALLOC && range_bad) |=> (rsp_done && rsp_err && !wr_valid && rsp_count == '0))
        else $error("out-of-range allocation not rejected cleanly");

    assert_free_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_FREE && free_ok) |=> (wr_valid && wr_src == SAFE && wr_line == $past(req_line) && !rsp_err))
        else $error("release did not push safe source");

    assert_free_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_FREE && !free_ok) |=> (rsp_done && rsp_err && !wr_valid))
        else $error("protected release not rejected");

endmodule

// File: rtl/irq_slot_alloc.sv
`timescale 1ns/1ps
// Interrupt line slot allocator top: joins table, free-line search and controller.
// Assumes masks are held stable while rst_n is low.
module irq_slot_alloc
    import irq_slot_pkg::*;
#(
    parameter int NUM_LINES = 12,
    parameter int NUM_SRCS  = 64,
    parameter int CNT_W     = 3,
    parameter int SAFE_SRC  = 0,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int MASK_W   = 1 << LINE_W,
    localparam int SRC_W    = $clog2(NUM_SRCS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MASK_W-1:0]  cfg_rsv_mask,
    input  logic [MASK_W-1:0]  cfg_byp_mask,
    output logic               cfg_err,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [CNT_W-1:0]   req_cnt,
    input  logic [LINE_W-1:0]  req_line,
    output logic               wr_valid,
    output logic [LINE_W-1:0]  wr_line,
    output logic [SRC_W-1:0]   wr_src,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic [LINE_W-1:0]  rsp_line,
    output logic [SRC_W-1:0]   rsp_src,
    output logic [CNT_W-1:0]   rsp_count
);

    ent_state_t [NUM_LINES-1:0]       st;
    logic [NUM_LINES-1:0][SRC_W-1:0]  src;
    logic [NUM_LINES-1:0]             free_vec;
    logic                             found;
    logic [LINE_W-1:0]                hit;
    logic                             set_en;
    logic [LINE_W-1:0]                set_idx;
    logic [SRC_W-1:0]                 set_src;
    logic                             clr_en;
    logic [LINE_W-1:0]                clr_idx;

    slot_table #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .MASK_W(MASK_W), .SRC_W(SRC_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rsv_mask(cfg_rsv_mask), .byp_mask(cfg_byp_mask),
        .set_en(set_en), .set_idx(set_idx), .set_src(set_src),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .st(st), .src(src), .free_vec(free_vec), .cfg_err(cfg_err)
    );

    slot_finder #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
    ) u_finder (
        .free_vec(free_vec), .found(found), .hit(hit)
    );

    slot_ctrl #(
        .NUM_LINES(NUM_LINES), .NUM_SRCS(NUM_SRCS), .LINE_W(LINE_W),
        .SRC_W(SRC_W), .CNT_W(CNT_W), .SAFE_SRC(SAFE_SRC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_cnt(req_cnt), .req_line(req_line),
        .st(st), .src(src), .free_vec(free_vec), .found(found), .hit(hit),
        .set_en(set_en), .set_idx(set_idx), .set_src(set_src),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .wr_valid(wr_valid), .wr_line(wr_line), .wr_src(wr_src),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_line(rsp_line),
        .rsp_src(rsp_src), .rsp_count(rsp_count)
    );

endmodule

// File: tb/irq_slot_alloc_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module irq_slot_alloc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_rsv_mask = '0;
    logic [15:0] cfg_byp_mask = '0;
    logic        cfg_err;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [5:0]  req_src = '0;
    logic [2:0]  req_cnt = '0;
    logic [3:0]  req_line = '0;
    logic        wr_valid;
    logic [3:0]  wr_line;
    logic [5:0]  wr_src;
    logic        rsp_done;
    logic        rsp_err;
    logic [3:0]  rsp_line;
    logic [5:0]  rsp_src;
    logic [2:0]  rsp_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_slot_alloc u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rsv_mask(cfg_rsv_mask), .cfg_byp_mask(cfg_byp_mask), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_cnt(req_cnt), .req_line(req_line),
        .wr_valid(wr_valid), .wr_line(wr_line), .wr_src(wr_src),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_line(rsp_line),
        .rsp_src(rsp_src), .rsp_count(rsp_count)
    );

    // Monitor: log selector writes and completions at the falling edge.
    int         wr_n = 0;
    logic [3:0] wl [0:63];
    logic [5:0] ws [0:63];
    int         done_n = 0;
    logic       d_err;
    logic [3:0] d_line;
    logic [5:0] d_src;
    logic [2:0] d_cnt;

    always @(negedge clk) begin
        if (rst_n && wr_valid === 1'b1 && wr_n < 64) begin
            wl[wr_n] = wr_line;
            ws[wr_n] = wr_src;
            wr_n++;
        end
        if (rst_n && rsp_done === 1'b1) begin
            d_err  = rsp_err;
            d_line = rsp_line;
            d_src  = rsp_src;
            d_cnt  = rsp_count;
            done_n++;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request and wait for its completion; reports write base.
    int  wbase;
    bit  busy_after;
    task automatic do_req(input logic op, input int s, input int c, input int ln);
        int dbase;
        int guard;
        guard = 0;
        while (!req_ready && guard < 100) begin step(); guard++; end
        wbase     = wr_n;
        dbase     = done_n;
        req_valid = 1'b1;
        req_op    = op;
        req_src   = 6'(s);
        req_cnt   = 3'(c);
        req_line  = 4'(ln);
        step();
        req_valid  = 1'b0;
        busy_after = !req_ready;
        guard = 0;
        while (done_n == dbase && guard < 100) begin step(); guard++; end
        chk(done_n == dbase + 1, "R9 one done per request", done_n - dbase, 1);
        step();
        chk(done_n == dbase + 1 && rsp_done == 1'b0, "R9 done lasts one cycle", done_n - dbase, 1);
    endtask

    task automatic chk_wr(input int k, input int ln, input int s, input string req);
        chk(wr_n > k && wl[k] == 4'(ln), req, (wr_n > k) ? int'(wl[k]) : -1, ln);
        chk(wr_n > k && ws[k] == 6'(s), req, (wr_n > k) ? int'(ws[k]) : -1, s);
    endtask

    task automatic apply_reset(input logic [15:0] rsv, input logic [15:0] byp);
        rst_n = 1'b0;
        cfg_rsv_mask = rsv;
        cfg_byp_mask = byp;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    // R1: mask bit above the table flags a configuration error.
    task automatic t_bad_config();
        apply_reset(16'h2000, 16'h0000);
        step();
        chk(cfg_err == 1'b1, "R1 cfg_err on index 13", cfg_err, 1);
        repeat (20) step();
        chk(cfg_err == 1'b1, "R1 cfg_err holds", cfg_err, 1);
    endtask

    // R1/R2: good masks (reserved 11,3; bypassed 7,3) and the safe sweep.
    task automatic t_reset_sweep();
        int base;
        int guard;
        int exp_lines [9] = '{0, 1, 2, 4, 5, 6, 8, 9, 10};
        apply_reset(16'h0808, 16'h0088);
        base = wr_n;
        step();
        chk(cfg_err == 1'b0, "R1 cfg_err clear", cfg_err, 0);
        chk(req_ready == 1'b0, "R2 not ready during sweep", req_ready, 0);
        guard = 0;
        while (!req_ready && guard < 50) begin step(); guard++; end
        chk(wr_n - base == 9, "R2 R1 sweep write count", wr_n - base, 9);
        for (int k = 0; k < 9; k++) chk_wr(base + k, exp_lines[k], 0, "R2 sweep line/source");
    endtask

    // R3/R4/R9: single then block allocation skipping the bypassed line.
    task automatic t_alloc_order();
        do_req(1'b0, 5, 1, 0);
        chk(d_err == 1'b0 && d_line == 4'd10, "R3 single grant line", d_line, 10);
        chk(wr_n - wbase == 1, "R4 one write per grant", wr_n - wbase, 1);
        chk_wr(wbase, 10, 5, "R4 write of line/source");
        do_req(1'b0, 20, 3, 0);
        chk(busy_after, "R9 not ready while allocating", int'(busy_after), 1);
        chk(wr_n - wbase == 3, "R4 block write count", wr_n - wbase, 3);
        chk_wr(wbase + 0, 9, 20, "R3 R4 block grant 0");
        chk_wr(wbase + 1, 8, 21, "R3 R4 block grant 1");
        chk_wr(wbase + 2, 6, 22, "R10 R4 block grant 2 skips bypassed 7");
        chk(d_err == 1'b0 && d_cnt == 3'd3, "R4 block count", d_cnt, 3);
        chk(d_line == 4'd6 && d_src == 6'd22, "R4 last grant reported", d_line, 6);
    endtask

    // R5: source range boundary and zero count.
    task automatic t_range();
        do_req(1'b0, 62, 3, 0);
        chk(d_err == 1'b1 && d_cnt == 3'd0, "R5 62+3 rejected", d_err, 1);
        chk(wr_n == wbase, "R5 no write on reject", wr_n - wbase, 0);
        do_req(1'b0, 7, 0, 0);
        chk(d_err == 1'b1 && wr_n == wbase, "R5 zero count rejected", d_err, 1);
        do_req(1'b0, 61, 3, 0);
        chk(d_err == 1'b0 && d_cnt == 3'd3, "R5 61+3 accepted", d_err, 0);
        chk_wr(wbase + 0, 5, 61, "R5 boundary grant 0");
        chk_wr(wbase + 1, 4, 62, "R5 boundary grant 1");
        chk_wr(wbase + 2, 2, 63, "R5 boundary grant 2");
    endtask

    // R7/R3: release pushes safe source; freed line is reused first.
    task automatic t_free_reuse();
        do_req(1'b1, 0, 0, 9);
        chk(d_err == 1'b0 && d_src == 6'd20, "R7 release returns held source", d_src, 20);
        chk(wr_n - wbase == 1, "R7 one safe write", wr_n - wbase, 1);
        chk_wr(wbase, 9, 0, "R7 safe write");
        do_req(1'b0, 40, 1, 0);
        chk(d_err == 1'b0 && d_line == 4'd9, "R3 freed high line reused", d_line, 9);
    endtask

    // R8/R10: protected and nonexistent lines reject release.
    task automatic t_free_reject();
        do_req(1'b1, 0, 0, 11);
        chk(d_err == 1'b1 && wr_n == wbase, "R8 reserved line 11", d_err, 1);
        do_req(1'b1, 0, 0, 3);
        chk(d_err == 1'b1 && wr_n == wbase, "R8 line 3 in both masks", d_err, 1);
        do_req(1'b1, 0, 0, 7);
        chk(d_err == 1'b1 && wr_n == wbase, "R8 bypassed line 7", d_err, 1);
        do_req(1'b1, 0, 0, 13);
        chk(d_err == 1'b1 && wr_n == wbase, "R8 nonexistent line 13", d_err, 1);
    endtask

    // R6/R10: exhaustion mid-block keeps earlier grants.
    task automatic t_exhaust();
        do_req(1'b0, 30, 4, 0);
        chk(d_err == 1'b1 && d_cnt == 3'd2, "R6 partial count", d_cnt, 2);
        chk(d_line == 4'd0, "R6 last granted line", d_line, 0);
        chk(wr_n - wbase == 2, "R6 writes only for grants", wr_n - wbase, 2);
        chk_wr(wbase + 0, 1, 30, "R6 grant 0");
        chk_wr(wbase + 1, 0, 31, "R6 grant 1");
        do_req(1'b0, 1, 1, 0);
        chk(d_err == 1'b1 && d_cnt == 3'd0 && wr_n == wbase, "R6 R10 full table rejects", d_cnt, 0);
    endtask

    // R7: no use count; a second free still succeeds with safe source.
    task automatic t_double_free();
        do_req(1'b1, 0, 0, 0);
        chk(d_err == 1'b0 && d_src == 6'd31, "R7 first release", d_src, 31);
        do_req(1'b1, 0, 0, 0);
        chk(d_err == 1'b0 && d_src == 6'd0, "R7 release of free line", d_src, 0);
        chk_wr(wbase, 0, 0, "R7 safe write again");
        do_req(1'b0, 9, 1, 0);
        chk(d_err == 1'b0 && d_line == 4'd0, "R7 released line reusable", d_line, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_bad_config();
        t_reset_sweep();
        t_alloc_order();
        t_range();
        t_free_reuse();
        t_free_reject();
        t_exhaust();
        t_double_free();
        repeat (3) step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule